// File: doc/BRIEF.md
# ROP3 Rectangle Fill and Blit Engine

This block is a compact 2D drawing engine. It owns a small framebuffer of `FB_W` x `FB_H` pixels, each `PIX_W` bits wide. It accepts 32-bit register writes, each tagged with a 4-bit register address, through a command queue. It supports two drawing operations: a rectangle fill and a screen-to-screen blit. Both work one pixel per clock. Each pixel result is a ternary raster operation (ROP3) that merges a pattern pixel, a source pixel and the existing destination pixel under an 8-bit code.

Software loads the configuration registers: clip window, pattern, ROP code and fill colour. It then writes the two position words and the size word of an operation, and the size word starts the operation. For a blit, the engine compares the source and destination corners and picks the walk direction itself, so overlapping rectangles copy correctly. Software paces its writes with the free-space readback, which is given in bytes. It waits for completion with the idle flag and inspects pixels through a combinational read port.

Top module: `rop_blit_engine`

## Requirements
- R1: `fifo_free_bytes` reads 4 times the number of free queue entries. It equals `FIFO_DEPTH*4` after reset and 0 when the queue is full.
- R2: A write presented while the queue is full is discarded. It sets `overflow`, which stays high until reset.
- R3: `idle` is high only when the queue is empty and no operation is running. The framebuffer is written only while an operation runs.
- R4: Register addresses are as follows:
  - 0 clip origin
  - 1 clip extent
  - 2 pattern shape
  - 3 pattern colour 0
  - 4 pattern colour 1
  - 5 pattern mask bits 31:0
  - 6 pattern mask bits 63:32
  - 7 ROP code
  - 8 fill colour
  - 9 fill corner
  - 10 fill size (starts a fill)
  - 11 blit source corner
  - 12 blit destination corner
  - 13 blit size (starts a blit)

  Writes to addresses 14 and 15 change nothing.
- R5: The fill corner word holds x in bits 31:16 and y in bits 15:0. The fill size word holds the width in bits 31:16 and the height in bits 15:0. During a fill the source pixel is the fill colour.
- R6: Each result bit is bit {P,S,D} of the ROP code, with the pattern bit as MSB of the index. The reset code is 0xCC, which copies the source. 0x55 inverts the destination, 0xF0 copies the pattern, 0xAA leaves the destination unchanged and 0x66 is source XOR destination.
- R7: The blit corner words hold y in bits 31:16 and x in bits 15:0. The blit size word holds the height in bits 31:16 and the width in bits 15:0, both as pixel counts. Source pixels outside the framebuffer read as zero.
- R8: A blit whose source and destination overlap gives the same result as copying from a snapshot of the source, for any relative position.
- R9: The clip origin word holds y in bits 31:16 and x in bits 15:0. The clip extent word holds the height in bits 31:16 and the width in bits 15:0. They reset to 0 and 0x80008000. Destination pixels outside the clip window or outside the framebuffer are not written.
- R10: A fill or blit with zero width or zero height writes no pixel and returns to idle.
- R11: Pattern shape 0 selects an 8x8 tile with mask index y[2:0]*8+x[2:0]. Shape 1 selects a 64x1 line with index x[5:0]. Shape 2 selects a 1x64 column with index y[5:0]. The indices use destination coordinates, and a mask bit of 1 selects colour 1, otherwise colour 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe into the command queue |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 32 | Register write data |
| fifo_free_bytes | output | $clog2(FIFO_DEPTH*4+1) | Free queue space in bytes |
| idle | output | 1 | Queue empty and no operation running |
| overflow | output | 1 | Sticky flag for a dropped write |
| rd_x | input | $clog2(FB_W) | Readback pixel x |
| rd_y | input | $clog2(FB_H) | Readback pixel y |
| rd_pix | output | PIX_W | Readback pixel value |

## Verification
The bench builds the engine with a 16x16 framebuffer of 8-bit pixels and a queue only 8 entries deep. With this size every pixel can be compared against a bench model after each operation. The shallow queue fills up behind a running full-frame fill after a few back-to-back writes, which makes the full-queue byte count, the dropped writes and the sticky overflow flag directly observable. The small frame also lets fills and blits cross its right and bottom edges, which exercises frame clipping and zero-valued out-of-frame source reads.

// File: rtl/rde_pkg.sv
package rde_pkg;

  // Register addresses carried with each queued write
  typedef enum logic [3:0] {
    A_CLIP_ORG  = 4'd0,
    A_CLIP_EXT  = 4'd1,
    A_PAT_SHAPE = 4'd2,
    A_PAT_C0    = 4'd3,
    A_PAT_C1    = 4'd4,
    A_PAT_MLO   = 4'd5,
    A_PAT_MHI   = 4'd6,
    A_ROP       = 4'd7,
    A_FILL_COL  = 4'd8,
    A_FILL_POS  = 4'd9,
    A_FILL_EXT  = 4'd10,
    A_BLT_SRC   = 4'd11,
    A_BLT_DST   = 4'd12,
    A_BLT_EXT   = 4'd13
  } reg_addr_e;

  typedef struct packed {
    logic [3:0]  addr;
    logic [31:0] data;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_BLIT} eng_state_e;

endpackage

// File: rtl/rde_cmd_fifo.sv
module rde_cmd_fifo #(
  parameter  int DEPTH = 256,
  parameter  int W     = 36,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];
  assign count   = cnt_q;

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      if (do_push != do_pop) cnt_q <= do_push ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/rde_pat_sel.sv
module rde_pat_sel #(
  parameter int PIX_W = 8
) (
  input  logic [1:0]       shape,
  input  logic [5:0]       px,
  input  logic [5:0]       py,
  input  logic [63:0]      mask,
  input  logic [PIX_W-1:0] col0,
  input  logic [PIX_W-1:0] col1,
  output logic [PIX_W-1:0] pix
);

  logic [5:0] idx;

  always_comb begin
    case (shape)
      2'd1:    idx = px;                     // 64x1 line
      2'd2:    idx = py;                     // 1x64 column
      default: idx = {py[2:0], px[2:0]};     // 8x8 tile
    endcase
  end

  assign pix = mask[idx] ? col1 : col0;

endmodule

// File: rtl/rde_fb.sv
module rde_fb #(
  parameter  int W     = 32,
  parameter  int H     = 32,
  parameter  int PIX_W = 8,
  localparam int AW    = $clog2(W * H)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic [AW-1:0]    src_addr,
  output logic [PIX_W-1:0] src_data,
  input  logic [AW-1:0]    dst_addr,
  output logic [PIX_W-1:0] dst_data,
  input  logic [AW-1:0]    rb_addr,
  output logic [PIX_W-1:0] rb_data
);

  logic [PIX_W-1:0] mem [W * H];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign src_data = mem[src_addr];
  assign dst_data = mem[dst_addr];
  assign rb_data  = mem[rb_addr];

endmodule

// File: rtl/rop_blit_engine.sv
module rop_blit_engine
  import rde_pkg::*;
#(
  parameter  int FB_W       = 32,
  parameter  int FB_H       = 32,
  parameter  int PIX_W      = 8,
  parameter  int FIFO_DEPTH = 256,
  localparam int XW         = $clog2(FB_W),
  localparam int YW         = $clog2(FB_H),
  localparam int FREE_W     = $clog2(FIFO_DEPTH * 4 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic [FREE_W-1:0] fifo_free_bytes,
  output logic              idle,
  output logic              overflow,
  input  logic [XW-1:0]     rd_x,
  input  logic [YW-1:0]     rd_y,
  output logic [PIX_W-1:0]  rd_pix
);

  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int AW = XW + YW;

  cmd_t             wr_cmd, head;
  logic [CW-1:0]    fifo_cnt;
  logic             fifo_full, fifo_empty, pop, busy;

  eng_state_e       state, state_d;
  logic [15:0]      cnt_x, cnt_x_d, cnt_y, cnt_y_d;
  logic [15:0]      clip_x, clip_y, clip_w, clip_h;
  logic [15:0]      fill_x, fill_y, bsrc_x, bsrc_y, bdst_x, bdst_y, op_w, op_h;
  logic [1:0]       pat_shape;
  logic [63:0]      pat_mask;
  logic [PIX_W-1:0] pat_c0, pat_c1, fill_col;
  logic [7:0]       rop_code;

  logic             is_blit, x_dec, y_dec, x_last, y_last;
  logic [15:0]      base_x, base_y, off_x, off_y;
  logic [16:0]      dst_x, dst_y, src_x, src_y, clip_xe, clip_ye;
  logic             dst_in, src_in, clip_in, fb_we, start_ok;
  logic [PIX_W-1:0] pat_pix, src_pix, dst_pix, fb_src, rop_pix;

  // ---------------- command queue ----------------
  assign wr_cmd = '{addr: wr_addr, data: wr_data};

  rde_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W($bits(cmd_t))) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_en),
    .din   (wr_cmd),
    .pop   (pop),
    .dout  (head),
    .count (fifo_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  assign busy            = (state != ST_IDLE);
  assign pop             = !busy && !fifo_empty;
  assign idle            = fifo_empty && !busy;
  assign fifo_free_bytes = FREE_W'((FIFO_DEPTH - 32'(fifo_cnt)) * 4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     overflow <= 1'b0;
    else if (wr_en && fifo_full)    overflow <= 1'b1;
  end

  // ---------------- register file (loaded only from popped entries) ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clip_x <= '0;       clip_y <= '0;
      clip_w <= 16'h8000; clip_h <= 16'h8000;
      fill_x <= '0; fill_y <= '0; bsrc_x <= '0; bsrc_y <= '0;
      bdst_x <= '0; bdst_y <= '0; op_w <= '0; op_h <= '0;
      pat_shape <= '0; pat_mask <= '0; pat_c0 <= '0; pat_c1 <= '0;
      fill_col <= '0; rop_code <= 8'hCC;
    end else if (pop) begin
      case (reg_addr_e'(head.addr))
        A_CLIP_ORG:  begin clip_y <= head.data[31:16]; clip_x <= head.data[15:0]; end
        A_CLIP_EXT:  begin clip_h <= head.data[31:16]; clip_w <= head.data[15:0]; end
        A_PAT_SHAPE: pat_shape <= head.data[1:0];
        A_PAT_C0:    pat_c0 <= head.data[PIX_W-1:0];
        A_PAT_C1:    pat_c1 <= head.data[PIX_W-1:0];
        A_PAT_MLO:   pat_mask[31:0]  <= head.data;
        A_PAT_MHI:   pat_mask[63:32] <= head.data;
        A_ROP:       rop_code <= head.data[7:0];
        A_FILL_COL:  fill_col <= head.data[PIX_W-1:0];
        A_FILL_POS:  begin fill_x <= head.data[31:16]; fill_y <= head.data[15:0]; end
        A_FILL_EXT:  begin op_w <= head.data[31:16]; op_h <= head.data[15:0]; end
        A_BLT_SRC:   begin bsrc_y <= head.data[31:16]; bsrc_x <= head.data[15:0]; end
        A_BLT_DST:   begin bdst_y <= head.data[31:16]; bdst_x <= head.data[15:0]; end
        A_BLT_EXT:   begin op_h <= head.data[31:16]; op_w <= head.data[15:0]; end
        default: ;
      endcase
    end
  end

  // ---------------- sequencer: next state ----------------
  assign start_ok = |head.data[31:16] && |head.data[15:0];
  assign x_last   = (cnt_x == op_w - 16'd1);
  assign y_last   = (cnt_y == op_h - 16'd1);

  always_comb begin
    state_d = state;
    cnt_x_d = cnt_x;
    cnt_y_d = cnt_y;
    if (!busy) begin
      cnt_x_d = '0;
      cnt_y_d = '0;
      if (pop && start_ok && head.addr == A_FILL_EXT) state_d = ST_FILL;
      if (pop && start_ok && head.addr == A_BLT_EXT)  state_d = ST_BLIT;
    end else if (x_last) begin
      cnt_x_d = '0;
      cnt_y_d = cnt_y + 16'd1;
      if (y_last) state_d = ST_IDLE;
    end else begin
      cnt_x_d = cnt_x + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt_x <= '0;
      cnt_y <= '0;
    end else begin
      state <= state_d;
      cnt_x <= cnt_x_d;
      cnt_y <= cnt_y_d;
    end
  end

  // ---------------- pixel datapath ----------------
  assign is_blit = (state == ST_BLIT);
  assign x_dec   = is_blit && (bdst_x > bsrc_x);
  assign y_dec   = is_blit && (bdst_y > bsrc_y);
  assign off_x   = x_dec ? (op_w - 16'd1 - cnt_x) : cnt_x;
  assign off_y   = y_dec ? (op_h - 16'd1 - cnt_y) : cnt_y;
  assign base_x  = is_blit ? bdst_x : fill_x;
  assign base_y  = is_blit ? bdst_y : fill_y;
  assign dst_x   = {1'b0, base_x} + {1'b0, off_x};
  assign dst_y   = {1'b0, base_y} + {1'b0, off_y};
  assign src_x   = {1'b0, bsrc_x} + {1'b0, off_x};
  assign src_y   = {1'b0, bsrc_y} + {1'b0, off_y};
  assign clip_xe = {1'b0, clip_x} + {1'b0, clip_w};
  assign clip_ye = {1'b0, clip_y} + {1'b0, clip_h};

  assign dst_in  = (dst_x < 17'(FB_W)) && (dst_y < 17'(FB_H));
  assign src_in  = (src_x < 17'(FB_W)) && (src_y < 17'(FB_H));
  assign clip_in = (dst_x >= {1'b0, clip_x}) && (dst_x < clip_xe) &&
                   (dst_y >= {1'b0, clip_y}) && (dst_y < clip_ye);
  assign fb_we   = busy && dst_in && clip_in;

  rde_pat_sel #(.PIX_W(PIX_W)) u_pat (
    .shape (pat_shape),
    .px    (dst_x[5:0]),
    .py    (dst_y[5:0]),
    .mask  (pat_mask),
    .col0  (pat_c0),
    .col1  (pat_c1),
    .pix   (pat_pix)
  );

  assign src_pix = is_blit ? (src_in ? fb_src : '0) : fill_col;

  for (genvar b = 0; b < PIX_W; b++) begin : g_rop
    assign rop_pix[b] = rop_code[{pat_pix[b], src_pix[b], dst_pix[b]}];
  end

  rde_fb #(.W(FB_W), .H(FB_H), .PIX_W(PIX_W)) u_fb (
    .clk      (clk),
    .we       (fb_we),
    .waddr    (AW'({dst_y[YW-1:0], dst_x[XW-1:0]})),
    .wdata    (rop_pix),
    .src_addr (AW'({src_y[YW-1:0], src_x[XW-1:0]})),
    .src_data (fb_src),
    .dst_addr (AW'({dst_y[YW-1:0], dst_x[XW-1:0]})),
    .dst_data (dst_pix),
    .rb_addr  (AW'({rd_y, rd_x})),
    .rb_data  (rd_pix)
  );

endmodule

// File: rtl/rde_chk.sv
module rde_chk #(
  parameter int FIFO_DEPTH = 256,
  parameter int FREE_W     = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [FREE_W-1:0] fifo_free_bytes,
  input logic              idle,
  input logic              overflow,
  input logic              busy,
  input logic              fb_we
);

  localparam logic [FREE_W-1:0] ALL_FREE = FREE_W'(FIFO_DEPTH * 4);

  // R1
  free_bytes_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_free_bytes[1:0] == 2'b00) && (fifo_free_bytes <= ALL_FREE));

  // R2
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R2
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_free_bytes == '0) |=> overflow);

  // R3
  idle_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !idle);

  // R3
  idle_queue_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (fifo_free_bytes == ALL_FREE));

  // R3
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> busy);

endmodule

bind rop_blit_engine rde_chk #(.FIFO_DEPTH(FIFO_DEPTH), .FREE_W(FREE_W)) u_rde_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .wr_en           (wr_en),
  .fifo_free_bytes (fifo_free_bytes),
  .idle            (idle),
  .overflow        (overflow),
  .busy            (busy),
  .fb_we           (fb_we)
);

// File: tb/test_rop_blit_engine.sv
`timescale 1ns/1ps
module test_rop_blit_engine;

  localparam int W = 16;
  localparam int H = 16;
  localparam int D = 8;

  logic       clk, rst_n, wr_en;
  logic [3:0] wr_addr;
  logic [31:0] wr_data;
  logic [5:0] fifo_free_bytes;
  logic       idle, overflow;
  logic [3:0] rd_x, rd_y;
  logic [7:0] rd_pix;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // bench-side mirror of the programmed state and the frame
  logic [7:0]  model [H][W];
  logic [7:0]  b_rop, b_fcol, b_pc0, b_pc1;
  logic [63:0] b_mask;
  int          b_shape, c_x, c_y, c_w, c_h;

  rop_blit_engine #(.FB_W(W), .FB_H(H), .PIX_W(8), .FIFO_DEPTH(D)) i_rop_blit_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fifo_free_bytes(fifo_free_bytes), .idle(idle), .overflow(overflow),
    .rd_x(rd_x), .rd_y(rd_y), .rd_pix(rd_pix)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // sum of minterms, weighted by the code bits
  function automatic logic [7:0] m_rop(logic [7:0] code, logic [7:0] p, logic [7:0] s, logic [7:0] d);
    logic [7:0] r = '0;
    for (int k = 0; k < 8; k++)
      if (code[k]) r |= ((k[2] ? p : ~p) & (k[1] ? s : ~s) & (k[0] ? d : ~d));
    return r;
  endfunction

  function automatic logic [7:0] m_pat(int x, int y);
    int idx;
    case (b_shape)
      1:       idx = x % 64;
      2:       idx = y % 64;
      default: idx = (y % 8) * 8 + (x % 8);
    endcase
    return b_mask[idx] ? b_pc1 : b_pc0;
  endfunction

  function automatic bit m_dst_ok(int x, int y);
    return x < W && y < H && x >= c_x && x < c_x + c_w && y >= c_y && y < c_y + c_h;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (!idle && n < 3000) begin @(negedge clk); n++; end
    chk(idle, req, "operation completes", 32'(idle), 1);
  endtask

  task automatic set_rop(input logic [7:0] c);  wr(7, 32'(c)); b_rop = c;  endtask
  task automatic set_fcol(input logic [7:0] c); wr(8, 32'(c)); b_fcol = c; endtask
  task automatic set_clip(input int x, input int y, input int w, input int h);
    wr(0, {16'(y), 16'(x)}); wr(1, {16'(h), 16'(w)});
    c_x = x; c_y = y; c_w = w; c_h = h;
  endtask

  task automatic do_fill(input int x0, input int y0, input int w, input int h, input string req);
    wr(9, {16'(x0), 16'(y0)}); wr(10, {16'(w), 16'(h)});
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        if (m_dst_ok(x0 + i, y0 + j))
          model[y0+j][x0+i] = m_rop(b_rop, m_pat(x0 + i, y0 + j), b_fcol, model[y0+j][x0+i]);
    wait_idle(req);
  endtask

  task automatic do_blit(input int sx, input int sy, input int dx, input int dy,
                         input int w, input int h, input string req);
    logic [7:0] snap [H][W];
    logic [7:0] s;
    snap = model;
    wr(11, {16'(sy), 16'(sx)}); wr(12, {16'(dy), 16'(dx)}); wr(13, {16'(h), 16'(w)});
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        if (m_dst_ok(dx + i, dy + j)) begin
          s = (sx + i < W && sy + j < H) ? snap[sy+j][sx+i] : 8'h00;
          model[dy+j][dx+i] = m_rop(b_rop, m_pat(dx + i, dy + j), s, snap[dy+j][dx+i]);
        end
    wait_idle(req);
  endtask

  task automatic check_frame(input string req, input string what);
    int bad = 0; int bx = 0; int by = 0;
    logic [7:0] a = '0; logic [7:0] e = '0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        rd_x = 4'(x); rd_y = 4'(y); #0.5;
        if (rd_pix !== model[y][x]) begin
          if (bad == 0) begin a = rd_pix; e = model[y][x]; bx = x; by = y; end
          bad++;
        end
      end
    if (bad != 0) $display("  first mismatch of %0d at x=%0d y=%0d", bad, bx, by);
    chk(bad == 0, req, what, 64'(a), 64'(e));
    @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(fifo_free_bytes == 6'd32, "R1", "free bytes after reset", 64'(fifo_free_bytes), 32);
    chk(idle == 1'b1, "R3", "idle after reset", 64'(idle), 1);
    chk(overflow == 1'b0, "R2", "overflow after reset", 64'(overflow), 0);
  endtask

  task automatic t_fill_basic();
    set_fcol(8'h3C);
    wr(9, 32'h0); wr(10, {16'd16, 16'd16});
    @(negedge clk); @(negedge clk);
    chk(idle == 1'b0, "R3", "idle low while filling", 64'(idle), 0);
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) model[y][x] = 8'h3C;
    wait_idle("R5");
    check_frame("R6", "full-frame copy fill with reset code");
    set_fcol(8'h81);
    do_fill(2, 9, 5, 3, "R5");
    check_frame("R5", "fill corner x/y and size w/h fields");
    set_fcol(8'h47);
    do_fill(12, 13, 10, 9, "R9");
    check_frame("R9", "fill crossing frame edges");
  endtask

  task automatic t_invert();
    set_rop(8'h55);
    do_fill(3, 2, 6, 5, "R6");
    check_frame("R6", "invert destination code 0x55");
  endtask

  task automatic t_zero_and_unused();
    set_rop(8'hCC); set_fcol(8'hFF);
    do_fill(1, 1, 0, 5, "R10");
    do_fill(1, 1, 5, 0, "R10");
    do_blit(0, 0, 4, 4, 0, 3, "R10");
    check_frame("R10", "zero-size fills and blit write nothing");
    wr(14, 32'hFFFF_FFFF); wr(15, 32'h0000_0001);
    wait_idle("R4");
    do_fill(0, 15, 2, 1, "R4");
    check_frame("R4", "writes to addresses 14/15 leave state unchanged");
  endtask

  task automatic t_clip();
    set_clip(4, 5, 6, 7);
    set_fcol(8'hA5);
    do_fill(0, 0, 16, 16, "R9");
    check_frame("R9", "fill limited to clip window");
    set_clip(0, 0, 16'h8000, 16'h8000);
  endtask

  task automatic t_pattern();
    set_rop(8'hF0);
    wr(3, 32'h12); wr(4, 32'hE7); wr(5, 32'h55AA_0FF0); wr(6, 32'h3CC3_9669);
    b_pc0 = 8'h12; b_pc1 = 8'hE7; b_mask = 64'h3CC3_9669_55AA_0FF0;
    wr(2, 0); b_shape = 0;
    do_fill(0, 0, 16, 8, "R11");
    wr(2, 1); b_shape = 1;
    do_fill(0, 8, 16, 4, "R11");
    wr(2, 2); b_shape = 2;
    do_fill(0, 12, 16, 4, "R11");
    check_frame("R11", "pattern shapes 8x8, 64x1 and 1x64");
  endtask

  task automatic t_stripes();
    set_rop(8'hCC);
    for (int x = 0; x < W; x++) begin
      set_fcol(8'(x * 16));
      do_fill(x, 0, 1, 16, "R5");
    end
    set_rop(8'h66);
    for (int y = 0; y < H; y++) begin
      set_fcol(8'(y));
      do_fill(0, y, 16, 1, "R6");
    end
    check_frame("R6", "source xor destination code 0x66");
    set_rop(8'hCC);
  endtask

  task automatic t_blits();
    do_blit(0, 0, 9, 10, 4, 3, "R7");
    check_frame("R7", "non-overlapping blit field order");
    do_blit(2, 2, 5, 4, 8, 7, "R8");
    check_frame("R8", "overlap, destination right and below");
    do_blit(6, 5, 3, 2, 9, 8, "R8");
    check_frame("R8", "overlap, destination left and above");
    do_blit(1, 9, 3, 9, 10, 3, "R8");
    do_blit(4, 12, 2, 12, 11, 2, "R8");
    check_frame("R8", "overlap within the same rows");
    do_blit(12, 0, 0, 12, 8, 3, "R7");
    check_frame("R7", "source outside frame reads zero");
  endtask

  task automatic t_overflow();
    set_rop(8'hAA);
    wr(9, 32'h0);
    wr(10, {16'd16, 16'd16});
    for (int k = 0; k < 12; k++) wr(14, 32'(k));
    chk(fifo_free_bytes == 6'd0, "R1", "free bytes with queue full", 64'(fifo_free_bytes), 0);
    chk(overflow == 1'b1, "R2", "overflow after dropped writes", 64'(overflow), 1);
    wait_idle("R3");
    chk(overflow == 1'b1, "R2", "overflow stays set", 64'(overflow), 1);
    chk(fifo_free_bytes == 6'd32, "R1", "free bytes after drain", 64'(fifo_free_bytes), 32);
    check_frame("R6", "destination-keep code 0xAA leaves frame");
  endtask

  initial begin
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_x = '0; rd_y = '0;
    b_rop = 8'hCC; b_fcol = 8'h00; b_pc0 = '0; b_pc1 = '0; b_mask = '0; b_shape = 0;
    c_x = 0; c_y = 0; c_w = 16'h8000; c_h = 16'h8000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_basic();
    t_invert();
    t_zero_and_unused();
    t_clip();
    t_pattern();
    t_stripes();
    t_blits();
    t_overflow();
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 150000) begin @(posedge clk); n++; end
    if (!done) chk(1'b0, "R3", "watchdog expired", n, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule